// File: doc/BRIEF.md
# Packed-Lane Integer Multiply-Add

This block is one stage of a video-style integer datapath. It picks a byte or a halfword out of each of two packed 32-bit operands, multiplies the two pieces, and adds a third 32-bit operand. It can then scale the sum down by a fixed right shift and clamp it to the 32-bit range. The second multiplicand can come from a 16-bit immediate instead of a register lane. Each operation says on its own whether each multiplicand is signed. Zero and sign flags can be refreshed from the result.

The surrounding pipeline presents one operation per strobe, with the operand values and the decoded control fields. One clock edge later the block shows the 32-bit result, the flags, a flag for unsupported operations and a one-cycle valid pulse. It has no handshake: a strobe is always accepted.

Top module: `pk_madd`

## Requirements
- R1: With its lane-mode bit clear, an operand supplies byte `sel`, which is bits [8*sel+7 : 8*sel], as the multiplicand.
- R2: With its lane-mode bit set, size code 0 supplies bits [15:0] and size code 1 supplies bits [31:16].
- R3: Size code 3 on A, or on B when B comes from the register, makes the result 0 and leaves `unsup_q` at 0. A reserved code on B's fields while B takes the immediate has no effect.
- R4: Size code 2 on A, or on B when B comes from the register, sets `unsup_q` to 1 and makes the result 0. The only exception is R3's reserved case, which takes precedence.
- R5: With `b_use_reg` at 0, B is the 16-bit immediate. It is sign-extended when `b_sgn` is 1 and zero-extended otherwise, and B's lane fields are ignored.
- R6: Each extracted sub-word is sign-extended when its own signed bit is 1 and zero-extended otherwise. C is signed when either multiplicand is signed and unsigned otherwise. The sum A*B+C is formed without loss.
- R7: Shift code 1 shifts the sum right by 7 and code 2 shifts it right by 15. The shift is arithmetic for a signed result and logical for an unsigned one. Codes 0 and 3 apply no shift.
- R8: With `sat_en` at 1, the shifted value is clamped. A signed result is held to [0x80000000, 0x7FFFFFFF]. An unsigned result is held to [0, 0xFFFFFFFF].
- R9: With `sat_en` at 0, the result is the low 32 bits of the shifted value.
- R10: On a strobe with `cc_en` at 1, `flag_z` becomes 1 exactly when the result is 0, and `flag_n` becomes result bit 31. Otherwise both flags hold.
- R11: `out_vld` is 1 in the cycle after a strobe and 0 otherwise. `result_q` and `unsup_q` change only after a strobe.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Operation strobe |
| a_val | input | 32 | Packed operand A |
| b_val | input | 32 | Packed operand B (register) |
| c_val | input | 32 | Addend C |
| imm16 | input | 16 | Immediate for B |
| a_sgn | input | 1 | A is signed |
| a_wide | input | 1 | A lane mode: 0 byte, 1 halfword |
| a_sel | input | 2 | A byte index or size code |
| b_sgn | input | 1 | B is signed |
| b_wide | input | 1 | B lane mode: 0 byte, 1 halfword |
| b_sel | input | 2 | B byte index or size code |
| b_use_reg | input | 1 | 1: B from register lane, 0: immediate |
| shift_code | input | 2 | Post-add right shift select |
| sat_en | input | 1 | Saturate instead of wrap |
| cc_en | input | 1 | Allow flag update |
| out_vld | output | 1 | Result valid pulse |
| result_q | output | 32 | Registered result |
| unsup_q | output | 1 | Unsupported size code seen |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Sign flag |

## Verification
The bench targets sign handling in mixed cases, such as a signed byte times an unsigned immediate. A design that extends the wrong way gives large positive results where small negative ones are due. The shift tests use negative sums, so a logical shift in place of an arithmetic one shows up as a wrong top bit. The saturation tests push both signed and unsigned sums past 32 bits, which catches a clamp that uses the wrong bounds or wraps instead. The reserved and unsupported size codes are applied on B both with and without the immediate, which exposes a design that decodes B's fields when they should be ignored. A design that lets the reserved code lose to the unsupported code is caught by the same tests.

// File: rtl/pk_madd.sv
module pk_madd #(
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_stb,
  input  logic [31:0]      a_val,
  input  logic [31:0]      b_val,
  input  logic [31:0]      c_val,
  input  logic [IMM_W-1:0] imm16,
  input  logic             a_sgn,
  input  logic             a_wide,
  input  logic [1:0]       a_sel,
  input  logic             b_sgn,
  input  logic             b_wide,
  input  logic [1:0]       b_sel,
  input  logic             b_use_reg,
  input  logic [1:0]       shift_code,
  input  logic             sat_en,
  input  logic             cc_en,
  output logic             out_vld,
  output logic [31:0]      result_q,
  output logic             unsup_q,
  output logic             flag_z,
  output logic             flag_n
);
  localparam logic signed [63:0] SMAX = 64'sh0000_0000_7fff_ffff;
  localparam logic signed [63:0] SMIN = 64'shffff_ffff_8000_0000;
  localparam logic signed [63:0] UMAX = 64'sh0000_0000_ffff_ffff;

  function automatic logic signed [63:0] lane_ext(input logic [31:0] v, input logic wide,
                                                  input logic [1:0] sel, input logic sg);
    logic [15:0] h;
    logic [7:0]  b;
    h = sel[0] ? v[31:16] : v[15:0];
    b = v[8*sel +: 8];
    if (wide) lane_ext = sg ? {{48{h[15]}}, h} : {48'd0, h};
    else      lane_ext = sg ? {{56{b[7]}}, b} : {56'd0, b};
  endfunction

  logic              res_sgn, rsv, nosup;
  logic signed [63:0] ax, bx, cx, sum, shd;
  logic [5:0]        sh;
  logic [31:0]       nxt;

  assign res_sgn = a_sgn | b_sgn;
  assign rsv   = (a_wide && a_sel == 2'd3) || (b_use_reg && b_wide && b_sel == 2'd3);
  assign nosup = !rsv && ((a_wide && a_sel == 2'd2) || (b_use_reg && b_wide && b_sel == 2'd2));

  assign ax  = lane_ext(a_val, a_wide, a_sel, a_sgn);
  assign bx  = b_use_reg ? lane_ext(b_val, b_wide, b_sel, b_sgn)
                         : (b_sgn ? {{(64-IMM_W){imm16[IMM_W-1]}}, imm16} : {{(64-IMM_W){1'b0}}, imm16});
  assign cx  = res_sgn ? {{32{c_val[31]}}, c_val} : {32'd0, c_val};
  assign sum = ax * bx + cx;
  assign sh  = (shift_code == 2'd1) ? 6'd7 : (shift_code == 2'd2) ? 6'd15 : 6'd0;
  assign shd = res_sgn ? (sum >>> sh) : $signed($unsigned(sum) >> sh);

  always_comb begin
    nxt = shd[31:0];
    if (sat_en) begin
      if (res_sgn) begin
        if (shd > SMAX)      nxt = SMAX[31:0];
        else if (shd < SMIN) nxt = SMIN[31:0];
      end else begin
        if (shd > UMAX)      nxt = UMAX[31:0];
        else if (shd < 0)    nxt = 32'd0;
      end
    end
    if (rsv || nosup) nxt = 32'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      result_q <= '0;
      unsup_q  <= 1'b0;
      flag_z   <= 1'b0;
      flag_n   <= 1'b0;
    end else begin
      out_vld <= in_stb;
      if (in_stb) begin
        result_q <= nxt;
        unsup_q  <= nosup;
        if (cc_en) begin
          flag_z <= (nxt == 32'd0);
          flag_n <= nxt[31];
        end
      end
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> out_vld);
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> !out_vld && $stable(result_q) && $stable(unsup_q));
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && a_wide && a_sel == 2'd3) |=> (result_q == 32'd0 && !unsup_q));
  a_r4_unsup_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && a_wide && a_sel == 2'd2 && !(b_use_reg && b_wide && b_sel == 2'd3))
      |=> (unsup_q && result_q == 32'd0));
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_stb && cc_en) |=> ($stable(flag_z) && $stable(flag_n)));
  a_r10_flags_track: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && cc_en) |=> (flag_z == (result_q == 32'd0) && flag_n == result_q[31]));
endmodule

// File: tb/tb_pk_madd.sv
module tb_pk_madd;
  logic clk = 1'b0, rst_n = 1'b0, in_stb = 1'b0;
  logic [31:0] a_val = '0, b_val = '0, c_val = '0;
  logic [15:0] imm16 = '0;
  logic a_sgn = 0, a_wide = 0, b_sgn = 0, b_wide = 0, b_use_reg = 0, sat_en = 0, cc_en = 0;
  logic [1:0] a_sel = '0, b_sel = '0, shift_code = '0;
  logic out_vld, unsup_q, flag_z, flag_n;
  logic [31:0] result_q;
  int checks = 0, fails = 0;
  logic ez = 0, en = 0;
  logic [31:0] last_r = '0;
  logic last_u = 0;

  always #4 clk = ~clk;

  pk_madd dut (.*);

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint pick(input logic [31:0] v, input logic w, input logic [1:0] s, input logic sg);
    longint x;
    if (w) begin
      x = (s == 2'd1) ? longint'(v >> 16) : longint'(v & 32'hffff);
      if (sg && x >= 32768) x -= 65536;
    end else begin
      x = longint'((v >> (8 * s)) & 32'hff);
      if (sg && x >= 128) x -= 256;
    end
    return x;
  endfunction

  function automatic void model(output logic [31:0] r, output logic u);
    longint a, b, c, s;
    bit sg, rz, bad;
    sg = a_sgn || b_sgn;
    rz = (a_wide && a_sel == 3) || (b_use_reg && b_wide && b_sel == 3);
    bad = !rz && ((a_wide && a_sel == 2) || (b_use_reg && b_wide && b_sel == 2));
    a = pick(a_val, a_wide, a_sel, a_sgn);
    if (b_use_reg) b = pick(b_val, b_wide, b_sel, b_sgn);
    else begin
      b = longint'(imm16);
      if (b_sgn && b >= 32768) b -= 65536;
    end
    c = longint'(c_val);
    if (sg && c >= 64'h8000_0000) c -= 64'h1_0000_0000;
    s = a * b + c;
    if (shift_code == 1) s = s >>> 7;
    else if (shift_code == 2) s = s >>> 15;
    if (sat_en) begin
      if (sg) begin
        if (s > 64'sh7fffffff) s = 64'sh7fffffff;
        if (s < -64'sh80000000) s = -64'sh80000000;
      end else begin
        if (s > 64'shffffffff) s = 64'shffffffff;
        if (s < 0) s = 0;
      end
    end
    r = (rz || bad) ? 32'd0 : s[31:0];
    u = bad;
  endfunction

  task automatic run(input string tag);
    logic [31:0] er;
    logic eu;
    model(er, eu);
    in_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_stb = 1'b0;
    if (cc_en) begin ez = (er == 0); en = er[31]; end
    last_r = er; last_u = eu;
    chk(tag, "result", result_q, er);
    chk(tag, "unsup", unsup_q, eu);
    chk("R11", "out_vld", out_vld, 1);
    chk("R10", "flag_z", flag_z, ez);
    chk("R10", "flag_n", flag_n, en);
  endtask

  task automatic setup(input logic [31:0] a, b, c, input logic [15:0] im,
                       input logic as, aw, input logic [1:0] asl,
                       input logic bs, bw, input logic [1:0] bsl, input logic bur,
                       input logic [1:0] shc, input logic sat, cc);
    a_val = a; b_val = b; c_val = c; imm16 = im;
    a_sgn = as; a_wide = aw; a_sel = asl;
    b_sgn = bs; b_wide = bw; b_sel = bsl; b_use_reg = bur;
    shift_code = shc; sat_en = sat; cc_en = cc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R12", "out_vld", out_vld, 0);
    chk("R12", "result", result_q, 0);
    chk("R12", "flags", {flag_z, flag_n, unsup_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    setup(32'h11223344, 0, 0, 16'd1, 0,0,2'd2, 0,0,0,0, 0,0,1); run("R1");
    chk("R1", "byte2", result_q, 32'h22);
    setup(32'h80000000, 0, 0, 16'd1, 1,0,2'd3, 1,0,0,0, 0,0,1); run("R6");
    chk("R6", "signed byte", result_q, 32'hffffff80);
    setup(32'h00000080, 0, 0, 16'hffff, 1,0,2'd0, 0,0,0,0, 0,0,1); run("R6");
    setup(32'hABCD0000, 0, 0, 16'd2, 0,1,2'd1, 0,0,0,0, 0,0,1); run("R2");
    chk("R2", "high half", result_q, 32'h1579A);
    setup(32'h1234ABCD, 32'h00050000, 32'd7, 0, 0,1,2'd0, 0,1,2'd1,1, 0,0,0); run("R2");
    setup(32'hffffffff, 0, 32'd9, 16'd5, 0,1,2'd3, 0,0,0,0, 0,0,1); run("R3");
    chk("R3", "zero", result_q, 0);
    setup(32'h7, 32'h3, 32'd1, 16'd4, 0,0,0, 0,1,2'd3,1, 0,0,1); run("R3");
    setup(32'h7, 32'h3, 32'd1, 16'd4, 0,0,0, 0,1,2'd3,0, 0,0,1); run("R5");
    chk("R5", "imm ignores fields", result_q, 29);
    setup(32'h7, 0, 32'd1, 16'd4, 0,1,2'd2, 0,0,0,0, 0,0,1); run("R4");
    chk("R4", "unsup", unsup_q, 1);
    setup(32'h7, 32'h1, 32'd1, 16'd4, 0,1,2'd2, 0,1,2'd3,1, 0,0,1); run("R3");
    setup(32'h1, 0, 0, 16'hffff, 0,0,0, 1,0,0,0, 0,0,1); run("R5");
    chk("R5", "sext imm", result_q, 32'hffffffff);
    setup(32'h8000, 0, 0, 16'd1, 1,1,0, 0,0,0,0, 2'd2,0,1); run("R7");
    chk("R7", "arith shift", result_q, 32'hffffffff);
    setup(32'h8000, 0, 0, 16'd1, 0,1,0, 0,0,0,0, 2'd2,0,1); run("R7");
    setup(32'h100, 0, 0, 16'd3, 0,1,0, 0,0,0,0, 2'd1,0,1); run("R7");
    setup(32'h100, 0, 0, 16'd3, 0,1,0, 0,0,0,0, 2'd3,0,1); run("R7");
    setup(32'hffff, 0, 32'hffffffff, 16'hffff, 0,1,0, 0,0,0,0, 0,1,1); run("R8");
    chk("R8", "unsigned clamp", result_q, 32'hffffffff);
    setup(32'hffff, 0, 32'hffffffff, 16'hffff, 0,1,0, 0,0,0,0, 0,0,1); run("R9");
    setup(32'h1, 0, 32'h7fffffff, 16'd1, 1,0,0, 0,0,0,0, 0,1,1); run("R8");
    setup(32'h1, 0, 32'h7fffffff, 16'd1, 1,0,0, 0,0,0,0, 0,0,1); run("R9");
    setup(32'hffff, 0, 32'h80000000, 16'd1, 1,1,0, 0,0,0,0, 0,1,1); run("R8");
    setup(32'h0, 0, 32'h0, 16'd1, 0,0,0, 0,0,0,0, 0,0,1); run("R10");
    setup(32'h5, 0, 32'h80000000, 16'd1, 0,0,0, 0,0,0,0, 0,0,0); run("R10");

    for (int i = 0; i < 3000; i++) begin
      setup($urandom, $urandom, $urandom, 16'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom));
      run("R6");
      if (($urandom & 3) == 0) begin
        a_val = $urandom; cc_en = 1'b1;
        @(negedge clk);
        chk("R11", "idle valid", out_vld, 0);
        chk("R11", "idle result", result_q, last_r);
        chk("R11", "idle unsup", unsup_q, last_u);
        chk("R10", "idle flags", {flag_z, flag_n}, {ez, en});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule